// File: doc/BRIEF.md
# Instruction Injection Sequencer

This unit sits between instruction fetch and the decoder of a small pipelined CPU. In normal flow it takes each 16-bit user instruction and zero-extends it into the 22-bit internal word that the decoder understands. The internal word has two more opcode bits and 6-bit register fields, which makes hidden registers such as the status register addressable.

When an event is requested (interrupt entry, trap entry or exception return), the unit stalls fetch. It then switches a 2:1 mux from the fetch path to a small sequence ROM and plays that event's short list of internal words. The decoder and datapath carry out the event with their ordinary operations, so no dedicated per-event state machine is needed. If a fetched instruction arrives in the cycle the sequence starts, the unit keeps it and issues it once the sequence has finished.

Fetch protocol: every beat with `fetch_valid` high is consumed by the unit. When `fetch_stall` is high in cycle t, fetch presents no beat in cycle t+1.

Top module: `seq_inject_unit`

## Requirements
- R1: With no sequence active and no held instruction, a valid 16-bit word {op[15:12], ra[11:8], rb[7:4], aux[3:0]} is issued in the same cycle as the 22-bit word {2'b00, op, 2'b00, ra, 2'b00, rb, aux}, with `dec_valid` high and `fetch_stall` low.
- R2: Words taken from the fetch path always have zero in bits [21:20], [15:14] and [9:8]. User code can therefore reach only registers 0 to 15. Register 32, the status register, is out of its reach.
- R3: Request bit 0 (interrupt entry) plays six ROM words from address 0, in this order: MOV SPSR,PSR; MOV EPC,PC; LDHI TMP,0xFF; ORLO TMP,0x7F; AND PSR,TMP; MOV PC,IVEC.
  - Word encodings: MOV = {6'h20, dst, src, 4'h0}, AND = {6'h21, dst, src, 4'h0}, LDHI = {6'h22, dst, imm10}, ORLO = {6'h23, dst, imm10}.
  - Register numbers: PSR = 32, PC = 33, EPC = 34, SPSR = 35, TMP = 36, IVEC = 37, TVEC = 38.
- R4: The interrupt-entry sequence loads 0xFF7F into TMP and ANDs the status register with it, which clears status bit 7 (the interrupt enable).
- R5: Each ROM entry carries an end marker. In the cycle after the marked word, the decoder is fed from the fetch path unless another request is pending.
- R6: When several requests are pending, the lowest request index is served first, one whole sequence at a time.
- R7: A running sequence cannot be interrupted. Its words issue on consecutive cycles at consecutive ROM addresses. Requests that arrive meanwhile are kept pending.
- R8: `fetch_stall` is high in exactly the cycles that issue a ROM word, starting with the cycle in which the request is first seen.
- R9: A beat that arrives in a sequence's first cycle is held and issued in the cycle after the last ROM word. No beat is lost or duplicated.
- R10: During reset `fetch_stall`, `seq_busy` and `dec_valid` are low when no input is active. Requests seen only during reset are discarded.
- R11: Request bit 1 (trap entry) plays MOV SPSR,PSR; MOV EPC,PC; MOV PC,TVEC from address 8. Request bit 2 (exception return) plays MOV PSR,SPSR; MOV PC,EPC from address 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_instr | input | 16 | Fetched user instruction |
| fetch_valid | input | 1 | Fetched instruction is present this cycle |
| evt_req | input | NUM_EVT | Event request pulses, bit 0 highest priority |
| fetch_stall | output | 1 | Fetch must not present a beat next cycle |
| seq_busy | output | 1 | ROM word on the decoder or a held instruction waiting |
| dec_word | output | 22 | Internal instruction word to the decoder |
| dec_valid | output | 1 | `dec_word` is valid |

## Verification
Pass-through is tried with all-zero, all-one and mixed-field user words. Only a word with every field set shows whether the zero bits are placed above each field and not shifted into it. A single interrupt pulse that coincides with a valid fetch beat shows that the exact word list is played, that the stall length is right and that the displaced beat comes out once and in order. Simultaneous and mid-sequence requests separate priority order from arrival order and show that a running sequence is not preempted. A request raised only during reset shows that reset discards pending state.

// File: rtl/inj_pkg.sv
package inj_pkg;
   localparam int U_OPW = 4;
   localparam int U_RW  = 4;
   localparam int AUXW  = 4;
   localparam int X_OPW = 6;
   localparam int X_RW  = 6;
   localparam int UW    = U_OPW + 2 * U_RW + AUXW;
   localparam int XW    = X_OPW + 2 * X_RW + AUXW;
   localparam int IMMW  = X_RW + AUXW;

   typedef logic [X_OPW-1:0] xop_t;
   typedef logic [X_RW-1:0]  xreg_t;
   typedef logic [XW-1:0]    xword_t;

   localparam xop_t OP_MOV  = 6'h20;
   localparam xop_t OP_AND  = 6'h21;
   localparam xop_t OP_LDHI = 6'h22;
   localparam xop_t OP_ORLO = 6'h23;
   localparam xop_t OP_NOP  = 6'h3E;

   localparam xreg_t R_PSR  = 6'd32;
   localparam xreg_t R_PC   = 6'd33;
   localparam xreg_t R_EPC  = 6'd34;
   localparam xreg_t R_SPSR = 6'd35;
   localparam xreg_t R_TMP  = 6'd36;
   localparam xreg_t R_IVEC = 6'd37;
   localparam xreg_t R_TVEC = 6'd38;

   function automatic xword_t enc_rr(input xop_t op, input xreg_t dst, input xreg_t src);
      return {op, dst, src, {AUXW{1'b0}}};
   endfunction

   function automatic xword_t enc_ri(input xop_t op, input xreg_t dst, input logic [7:0] imm);
      return {op, dst, IMMW'(imm)};
   endfunction

   // {last, word}; slot k holds the sequence for event k
   function automatic logic [XW:0] rom_entry(input int addr, input int slot);
      int     evt;
      int     idx;
      xword_t w;
      logic   last;
      evt  = addr / slot;
      idx  = addr % slot;
      w    = {OP_NOP, {(XW-X_OPW){1'b0}}};
      last = 1'b1;
      case (evt)
         0: case (idx)
               0: begin w = enc_rr(OP_MOV, R_SPSR, R_PSR);  last = 1'b0; end
               1: begin w = enc_rr(OP_MOV, R_EPC, R_PC);    last = 1'b0; end
               2: begin w = enc_ri(OP_LDHI, R_TMP, 8'hFF);  last = 1'b0; end
               3: begin w = enc_ri(OP_ORLO, R_TMP, 8'h7F);  last = 1'b0; end
               4: begin w = enc_rr(OP_AND, R_PSR, R_TMP);   last = 1'b0; end
               5: begin w = enc_rr(OP_MOV, R_PC, R_IVEC);   last = 1'b1; end
               default: ;
            endcase
         1: case (idx)
               0: begin w = enc_rr(OP_MOV, R_SPSR, R_PSR);  last = 1'b0; end
               1: begin w = enc_rr(OP_MOV, R_EPC, R_PC);    last = 1'b0; end
               2: begin w = enc_rr(OP_MOV, R_PC, R_TVEC);   last = 1'b1; end
               default: ;
            endcase
         2: case (idx)
               0: begin w = enc_rr(OP_MOV, R_PSR, R_SPSR);  last = 1'b0; end
               1: begin w = enc_rr(OP_MOV, R_PC, R_EPC);    last = 1'b1; end
               default: ;
            endcase
         default: ;
      endcase
      return {last, w};
   endfunction
endpackage

// File: rtl/inj_widen.sv
module inj_widen
   import inj_pkg::*;
(
   input  logic [UW-1:0] uin,
   output xword_t        xout
);
   localparam int OP_LSB = UW - U_OPW;
   localparam int RA_LSB = OP_LSB - U_RW;
   localparam int RB_LSB = RA_LSB - U_RW;
   localparam int OPX    = X_OPW - U_OPW;
   localparam int RX     = X_RW - U_RW;

   assign xout = {{OPX{1'b0}}, uin[OP_LSB +: U_OPW],
                  {RX{1'b0}},  uin[RA_LSB +: U_RW],
                  {RX{1'b0}},  uin[RB_LSB +: U_RW],
                  uin[AUXW-1:0]};
endmodule

// File: rtl/inj_seq_rom.sv
module inj_seq_rom
   import inj_pkg::*;
#(
   parameter int DEPTH      = 32,
   parameter int SLOT_WORDS = 8,
   localparam int AW        = $clog2(DEPTH)
)(
   input  logic [AW-1:0] addr,
   output xword_t        word,
   output logic          last
);
   logic [XW:0] mem [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_row
      assign mem[a] = rom_entry(a, SLOT_WORDS);
   end

   assign word = mem[addr][XW-1:0];
   assign last = mem[addr][XW];
endmodule

// File: rtl/inj_req_arbiter.sv
module inj_req_arbiter #(
   parameter int N  = 3,
   localparam int EW = (N > 1) ? $clog2(N) : 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [EW-1:0] sel,
   output logic          any
);
   always_comb begin
      grant = '0;
      sel   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            sel      = EW'(i);
         end
      end
   end

   assign any = |req;

   assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~req) == '0));
   assert_index0_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req[0] |-> grant[0]);
endmodule

// File: rtl/inj_seq_ctrl.sv
module inj_seq_ctrl #(
   parameter int NUM_EVT    = 3,
   parameter int ROM_DEPTH  = 32,
   parameter int SLOT_WORDS = 8,
   localparam int AW        = $clog2(ROM_DEPTH),
   localparam int EW        = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_req,
   input  logic               rom_last,
   output logic [AW-1:0]      rom_addr,
   output logic               rom_sel
);
   logic               active;
   logic [AW-1:0]      ptr;
   logic [NUM_EVT-1:0] pending;
   logic [NUM_EVT-1:0] req_vec;
   logic [NUM_EVT-1:0] grant;
   logic [EW-1:0]      sel;
   logic               any;
   logic               start;

   assign req_vec = pending | evt_req;

   inj_req_arbiter #(.N(NUM_EVT)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req_vec),
      .grant(grant), .sel(sel), .any(any)
   );

   assign start    = !active && any;
   assign rom_sel  = active || start;
   assign rom_addr = active ? ptr : AW'(int'(sel) * SLOT_WORDS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         ptr     <= '0;
         pending <= '0;
      end else begin
         pending <= start ? (req_vec & ~grant) : req_vec;
         if (rom_sel && !rom_last) begin
            active <= 1'b1;
            ptr    <= rom_addr + AW'(1);
         end else begin
            active <= 1'b0;
         end
      end
   end

   assert_seq_contiguous_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_sel && !rom_last) |=> (rom_sel && rom_addr == $past(rom_addr) + AW'(1)));
   assert_end_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_sel && rom_last) |=> !active);
endmodule

// File: rtl/seq_inject_unit.sv
module seq_inject_unit
   import inj_pkg::*;
#(
   parameter int NUM_EVT    = 3,
   parameter int ROM_DEPTH  = 32,
   parameter int SLOT_WORDS = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [UW-1:0]      fetch_instr,
   input  logic               fetch_valid,
   input  logic [NUM_EVT-1:0] evt_req,
   output logic               fetch_stall,
   output logic               seq_busy,
   output logic [XW-1:0]      dec_word,
   output logic               dec_valid
);
   localparam int AW = $clog2(ROM_DEPTH);

   if (ROM_DEPTH < 32 || ROM_DEPTH > 64) begin : g_bad_depth
      $error("ROM_DEPTH must lie in 32..64");
   end
   if (SLOT_WORDS < 6) begin : g_bad_slot
      $error("SLOT_WORDS too small for the interrupt-entry sequence");
   end
   if (NUM_EVT * SLOT_WORDS > ROM_DEPTH) begin : g_bad_fit
      $error("event slots exceed ROM_DEPTH");
   end

   logic [AW-1:0] rom_addr;
   logic          rom_sel;
   logic          rom_last;
   xword_t        rom_word;
   xword_t        user_word;
   logic [UW-1:0] hold_instr;
   logic          hold_valid;
   logic [UW-1:0] user_src;

   inj_seq_ctrl #(.NUM_EVT(NUM_EVT), .ROM_DEPTH(ROM_DEPTH), .SLOT_WORDS(SLOT_WORDS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .evt_req(evt_req),
      .rom_last(rom_last), .rom_addr(rom_addr), .rom_sel(rom_sel)
   );

   inj_seq_rom #(.DEPTH(ROM_DEPTH), .SLOT_WORDS(SLOT_WORDS)) u_rom (
      .addr(rom_addr), .word(rom_word), .last(rom_last)
   );

   assign user_src = hold_valid ? hold_instr : fetch_instr;

   inj_widen u_widen (.uin(user_src), .xout(user_word));

   assign dec_word    = rom_sel ? rom_word : user_word;
   assign dec_valid   = rom_sel || hold_valid || fetch_valid;
   assign fetch_stall = rom_sel;
   assign seq_busy    = rom_sel || hold_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_instr <= '0;
      end else if (rom_sel && fetch_valid) begin
         hold_valid <= 1'b1;
         hold_instr <= fetch_instr;
      end else if (!rom_sel) begin
         hold_valid <= 1'b0;
      end
   end

   assert_user_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !fetch_stall) |->
         (dec_word[21:20] == 2'b00 && dec_word[15:14] == 2'b00 && dec_word[9:8] == 2'b00));
   assert_displaced_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_stall && fetch_valid) |=> hold_valid);
   assert_hold_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_valid && !fetch_stall) |=> !hold_valid);
endmodule

// File: tb/sim_seq_inject_unit.sv
module sim_seq_inject_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] fi = '0;
   logic        fv = 1'b0;
   logic [2:0]  er = '0;
   logic        fetch_stall, seq_busy, dec_valid;
   logic [21:0] dec_word;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   seq_inject_unit u0 (
      .clk(clk), .rst_n(rst_n), .fetch_instr(fi), .fetch_valid(fv), .evt_req(er),
      .fetch_stall(fetch_stall), .seq_busy(seq_busy), .dec_word(dec_word), .dec_valid(dec_valid)
   );

   localparam logic [15:0] UIN  [6] = '{16'h0000, 16'hFFFF, 16'h1234, 16'hA5C3, 16'h8F01, 16'h0F0F};
   localparam logic [21:0] UEXP [6] = '{22'h000000, 22'h0F3CFF, 22'h010834, 22'h0A14C3, 22'h083C01, 22'h003C0F};

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [21:0] enc(input logic [5:0] op, input logic [5:0] ra, input logic [9:0] lo);
      return {op, ra, lo};
   endfunction
   function automatic logic [21:0] rr(input logic [5:0] op, input logic [5:0] d, input logic [5:0] s);
      return enc(op, d, {s, 4'h0});
   endfunction
   function automatic logic [21:0] uwide(input int k);
      return {6'h03, 6'h00, 6'h00, 4'(k)};
   endfunction
   function automatic logic [21:0] seqw(input int evt, input int i);
      case (evt)
         0: case (i)
               0: return rr(6'h20, 6'd35, 6'd32);
               1: return rr(6'h20, 6'd34, 6'd33);
               2: return enc(6'h22, 6'd36, 10'h0FF);
               3: return enc(6'h23, 6'd36, 10'h07F);
               4: return rr(6'h21, 6'd32, 6'd36);
               default: return rr(6'h20, 6'd33, 6'd37);
            endcase
         1: case (i)
               0: return rr(6'h20, 6'd35, 6'd32);
               1: return rr(6'h20, 6'd34, 6'd33);
               default: return rr(6'h20, 6'd33, 6'd38);
            endcase
         default: return (i == 0) ? rr(6'h20, 6'd32, 6'd35) : rr(6'h20, 6'd33, 6'd34);
      endcase
   endfunction
   function automatic int seqlen(input int evt);
      return (evt == 0) ? 6 : (evt == 1) ? 3 : 2;
   endfunction

   logic [21:0] logw [256];
   int          logn;
   logic [21:0] expw [256];
   int          expn;
   int          stall_cyc;

   task automatic push(input logic [21:0] w);
      expw[expn] = w;
      expn++;
   endtask
   task automatic push_seq(input int evt);
      for (int i = 0; i < seqlen(evt); i++) push(seqw(evt, i));
   endtask

   task automatic run(input int nuser, input int c1, input logic [2:0] m1,
                      input int c2, input logic [2:0] m2, input int ncyc);
      int k = 0;
      bit sp = 1'b0;
      logn = 0;
      stall_cyc = 0;
      for (int c = 0; c < ncyc; c++) begin
         @(posedge clk); #1;
         fv = !sp && (k < nuser);
         fi = 16'h3000 | 16'(k);
         if (fv) k++;
         er = (c == c1) ? m1 : (c == c2) ? m2 : 3'b000;
         @(negedge clk);
         sp = fetch_stall;
         if (fetch_stall) stall_cyc++;
         if (dec_valid && logn < 256) begin
            logw[logn] = dec_word;
            logn++;
         end
      end
      @(posedge clk); #1;
      fv = 1'b0;
      er = '0;
   endtask

   task automatic compare(input string req);
      chk(logn == expn, req, 32'(logn), 32'(expn));
      for (int i = 0; i < expn && i < logn; i++)
         chk(logw[i] == expw[i], req, 32'(logw[i]), 32'(expw[i]));
   endtask

   initial begin
      #(200000 * 10);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // R10: reset state, then a request raised only inside reset
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(!fetch_stall && !seq_busy && !dec_valid, "R10 reset outputs", {29'd0, fetch_stall, seq_busy, dec_valid}, 32'd0);
      @(posedge clk); #1 er = 3'b111;
      @(posedge clk); #1 er = 3'b000;
      @(posedge clk); #1 rst_n = 1'b1;
      stall_cyc = 0;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         if (fetch_stall || dec_valid) stall_cyc++;
      end
      chk(stall_cyc == 0, "R10 request in reset discarded", 32'(stall_cyc), 32'd0);

      // R1 R2: widening vectors, including all-ones fields
      for (int i = 0; i < 6; i++) begin
         @(posedge clk); #1;
         fv = 1'b1;
         fi = UIN[i];
         @(negedge clk);
         chk(dec_valid && !fetch_stall && dec_word == UEXP[i], "R1 R2 widen", 32'(dec_word), 32'(UEXP[i]));
      end
      @(posedge clk); #1 fv = 1'b0;

      // R3 R4 R8 R9: interrupt pulse that lands on a valid fetch beat
      expn = 0;
      push(uwide(0)); push(uwide(1));
      push_seq(0);
      for (int k = 2; k < 6; k++) push(uwide(k));
      run(6, 2, 3'b001, -1, 3'b000, 20);
      compare("R3 R9 interrupt stream");
      chk(stall_cyc == 6, "R8 stall length", 32'(stall_cyc), 32'd6);
      chk(logw[6] == enc(6'h21, 6'd32, {6'd36, 4'h0}) && logw[4] == enc(6'h22, 6'd36, 10'h0FF)
          && logw[5] == enc(6'h23, 6'd36, 10'h07F), "R4 clear enable", 32'(logw[6]),
          32'(enc(6'h21, 6'd32, {6'd36, 4'h0})));

      // R6 R7 R11: simultaneous bits 0 and 2, then bit 1 mid-sequence
      expn = 0;
      push_seq(0);
      push_seq(1);
      push_seq(2);
      run(0, 0, 3'b101, 3, 3'b010, 16);
      compare("R6 R7 R11 priority stream");
      chk(stall_cyc == 11, "R7 R8 total stall", 32'(stall_cyc), 32'd11);

      // R5: fetch path back after the last marked word
      @(posedge clk); #1;
      fv = 1'b1;
      fi = 16'h1234;
      @(negedge clk);
      chk(!fetch_stall && dec_valid && dec_word == 22'h010834, "R5 return to fetch", 32'(dec_word), 32'h010834);
      @(posedge clk); #1 fv = 1'b0;
      @(negedge clk);
      chk(!seq_busy && !dec_valid, "R5 idle after", {30'd0, seq_busy, dec_valid}, 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule